// File: doc/BRIEF.md
# Accumulator Register Bank with Field Views

This block is the operand store of a small DSP-style datapath. It holds sixteen general-purpose words, four accumulators (named a, b, c and d) and a product word p. Each accumulator is 32 bits wide. The top 8 bits hold an exponent and the low 24 bits hold a mantissa. Every accumulator can be reached through three addresses: one for the whole word, one that exposes only the exponent and one that exposes only the mantissa.

Operands are named by a 9-bit specifier. Its upper 3 bits give a type and its lower 6 bits give an index. The bank has two combinational read ports and one write port. A write through a field view merges into the selected field and leaves the other field alone. The bank also executes two immediate-load instruction words:
- a 24-bit integer load, which fills a whole register with a sign-extended value;
- a float-field load, which fills one field of accumulator c or d.

Top module: `acc_field_bank`

## Requirements
- R1: After reset, every addressable location reads zero.
- R2: A specifier with type 0 or type 3 and an index from 0x00 to 0x0F reads and writes the general word at that index. A specifier of any other type selects nothing: it reads zero and a write through it is ignored. Reads are combinational.
- R3: Each read port raises its destination flag exactly when the type field (bits 8:6) of its specifier is 3, whatever the index.
- R4: Index 0x10+3k, for k from 0 to 3 (a, b, c, d), reads and writes accumulator k as a full 32-bit word. Index 0x1C does the same for p.
- R5: Index 0x11+3k is the exponent view of accumulator k. A read returns bits 31:24 in bits 7:0 with zeros above. A write copies write-data bits 7:0 into bits 31:24 and leaves bits 23:0 unchanged.
- R6: Index 0x12+3k is the mantissa view of accumulator k. A read returns bits 23:0 with zeros above. A write copies write-data bits 23:0 into bits 23:0 and leaves bits 31:24 unchanged.
- R7: Every other index, including 0x1D to 0x3F and the tied-off queue ports at 0x21 and 0x22, reads zero. A write to any of them changes no location.
- R8: A load word with bits 31:26 = 001110 is an integer load. Bits 25:24 pick the target: 0 is p, 1 is a, 2 is b, 3 is d. Bits 23:0 are sign-extended to 32 bits and written as the whole word.
- R9: A load word with bits 31:26 = 010110 is a float-field load. Bits 25:24 pick the target: 0 is the exponent of c, 1 is the mantissa of c, 2 is the exponent of d, 3 is the mantissa of d. An exponent load takes value bits 7:0. A mantissa load takes value bits 23:0. The other field is kept.
- R10: A load strobe whose opcode matches neither load changes no location.
- R11: When a recognised load and a port write occur in the same cycle, the load is performed and the port write is dropped, even if the two target different locations.
- R12: A write takes effect at the next rising clock edge. In the cycle of the write, both read ports still return the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_spec | input | 9 | Read port 0 specifier |
| rd0_data | output | 32 | Read port 0 data |
| rd0_dst | output | 1 | Read port 0 specifier has type 3 |
| rd1_spec | input | 9 | Read port 1 specifier |
| rd1_data | output | 32 | Read port 1 data |
| rd1_dst | output | 1 | Read port 1 specifier has type 3 |
| wr_en | input | 1 | Port write strobe |
| wr_spec | input | 9 | Port write specifier |
| wr_data | input | 32 | Port write data, in view format |
| ld_valid | input | 1 | Immediate-load strobe |
| ld_word | input | 32 | Immediate-load instruction word |

## Verification
The bench goes after the edges of the index map:
- 0x0F next to 0x10;
- each view triple of each accumulator;
- 0x1C next to 0x1D;
- the queue indices;
- types other than 0 and 3.

An off-by-one decoder shows up here as a write landing on a neighbouring register, or as a non-zero read of a hole.

Field writes are driven with all-ones data. A merge that is not confined to its field corrupts the other half of the accumulator.

Integer loads use negative values, so a missing sign extension leaves the upper byte at zero.

Loads collide with port writes in the same cycle. A wrong priority lets the port write land, or lets both writes land.

Every write is read back in its own cycle, so a read path that forwards the new value is caught.

// File: rtl/acc_bank_pkg.sv
package acc_bank_pkg;

  // which part of an accumulator an access touches
  typedef enum logic [1:0] {
    F_WHOLE = 2'd0,
    F_EXP   = 2'd1,
    F_MANT  = 2'd2
  } fview_e;

  localparam int SPEC_W = 9;
  localparam int TYPE_W = 3;
  localparam int IDX_W  = 6;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 6;
  localparam int IMM_W  = 24;

  localparam logic [TYPE_W-1:0] TY_PLAIN = 3'd0;
  localparam logic [TYPE_W-1:0] TY_DEST  = 3'd3;

  localparam logic [OPC_W-1:0] OPC_INT24 = 6'b001110;
  localparam logic [OPC_W-1:0] OPC_FLD   = 6'b010110;

  // number of addresses per accumulator (whole, exponent, mantissa)
  localparam int VIEWS = 3;

endpackage

// File: rtl/acc_spec_decode.sv
module acc_spec_decode
  import acc_bank_pkg::*;
#(
  parameter int GP_N   = 16,
  parameter int ACC_N  = 4,
  parameter int SLOT_W = 5
) (
  input  logic [SPEC_W-1:0] spec,
  output logic              hit,
  output logic [SLOT_W-1:0] slot,
  output fview_e            field
);

  localparam int ACC_BASE = GP_N;
  localparam int P_IDX    = GP_N + VIEWS * ACC_N;

  logic [TYPE_W-1:0] typ;
  logic [IDX_W-1:0]  idx;

  assign typ = spec[SPEC_W-1:IDX_W];
  assign idx = spec[IDX_W-1:0];

  // Indices past p (0x21/0x22 queue ports among them) fall through as misses.
  always_comb begin
    hit   = 1'b0;
    slot  = '0;
    field = F_WHOLE;
    if (typ == TY_PLAIN || typ == TY_DEST) begin
      if (int'(idx) < GP_N) begin
        hit  = 1'b1;
        slot = SLOT_W'(idx);
      end
      for (int k = 0; k < ACC_N; k++) begin
        for (int f = 0; f < VIEWS; f++) begin
          if (int'(idx) == ACC_BASE + VIEWS * k + f) begin
            hit   = 1'b1;
            slot  = SLOT_W'(GP_N + k);
            field = fview_e'(2'(f));
          end
        end
      end
      if (int'(idx) == P_IDX) begin
        hit  = 1'b1;
        slot = SLOT_W'(GP_N + ACC_N);
      end
    end
  end

endmodule

// File: rtl/acc_imm_decode.sv
module acc_imm_decode
  import acc_bank_pkg::*;
#(
  parameter int GP_N   = 16,
  parameter int ACC_N  = 4,
  parameter int DW     = 32,
  parameter int SLOT_W = 5
) (
  input  logic              valid,
  input  logic [INSN_W-1:0] word,
  output logic              hit,
  output logic [SLOT_W-1:0] slot,
  output fview_e            field,
  output logic [DW-1:0]     data
);

  localparam int SL_A = GP_N;
  localparam int SL_B = GP_N + 1;
  localparam int SL_C = GP_N + 2;
  localparam int SL_D = GP_N + 3;
  localparam int SL_P = GP_N + ACC_N;

  logic [OPC_W-1:0] opc;
  logic [1:0]       dsel;
  logic [IMM_W-1:0] val;

  assign opc  = word[INSN_W-1 -: OPC_W];
  assign dsel = word[IMM_W+1:IMM_W];
  assign val  = word[IMM_W-1:0];

  function automatic logic [DW-1:0] widen_signed(input logic [IMM_W-1:0] v);
    return {{(DW-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] widen_zero(input logic [IMM_W-1:0] v);
    return {{(DW-IMM_W){1'b0}}, v};
  endfunction

  always_comb begin
    hit   = 1'b0;
    slot  = '0;
    field = F_WHOLE;
    data  = '0;
    if (valid && opc == OPC_INT24) begin
      hit  = 1'b1;
      data = widen_signed(val);
      unique case (dsel)
        2'd0: slot = SLOT_W'(SL_P);
        2'd1: slot = SLOT_W'(SL_A);
        2'd2: slot = SLOT_W'(SL_B);
        default: slot = SLOT_W'(SL_D);
      endcase
    end else if (valid && opc == OPC_FLD) begin
      hit   = 1'b1;
      data  = widen_zero(val);  // exponent sits in bits 7:0 of view format
      slot  = dsel[1] ? SLOT_W'(SL_D) : SLOT_W'(SL_C);
      field = dsel[0] ? F_MANT : F_EXP;
    end
  end

endmodule

// File: rtl/acc_slot_reg.sv
module acc_slot_reg #(
  parameter int DW    = 32,
  parameter int EXP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [EXP_W-1:0]  d_hi,
  input  logic [DW-EXP_W-1:0] d_lo,
  output logic [DW-1:0]     q
);

  localparam int MANT_W = DW - EXP_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (we_hi) q[DW-1:MANT_W] <= d_hi;
      if (we_lo) q[MANT_W-1:0]  <= d_lo;
    end
  end

  // R5: exponent-only write lands its byte and keeps the mantissa
  a_r5_exp_keeps_mant: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi && !we_lo) |=> (q[MANT_W-1:0] == $past(q[MANT_W-1:0])) &&
                          (q[DW-1:MANT_W] == $past(d_hi)));

  // R6: mantissa-only write keeps the exponent
  a_r6_mant_keeps_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && !we_hi) |=> (q[DW-1:MANT_W] == $past(q[DW-1:MANT_W])) &&
                          (q[MANT_W-1:0] == $past(d_lo)));

  // R7: a location that nothing selects holds its value
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_hi && !we_lo) |=> $stable(q));

endmodule

// File: rtl/acc_field_bank.sv
module acc_field_bank
  import acc_bank_pkg::*;
#(
  parameter int GP_N  = 16,
  parameter int ACC_N = 4,
  parameter int DW    = 32,
  parameter int EXP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPEC_W-1:0] rd0_spec,
  output logic [DW-1:0]     rd0_data,
  output logic              rd0_dst,
  input  logic [SPEC_W-1:0] rd1_spec,
  output logic [DW-1:0]     rd1_data,
  output logic              rd1_dst,
  input  logic              wr_en,
  input  logic [SPEC_W-1:0] wr_spec,
  input  logic [DW-1:0]     wr_data,
  input  logic              ld_valid,
  input  logic [INSN_W-1:0] ld_word
);

  localparam int MANT_W = DW - EXP_W;
  localparam int SLOTS  = GP_N + ACC_N + 1;
  localparam int SLOT_W = $clog2(SLOTS);

  function automatic logic [DW-1:0] view_of(input logic [DW-1:0] w, input fview_e f);
    unique case (f)
      F_EXP:   return {{MANT_W{1'b0}}, w[DW-1:MANT_W]};
      F_MANT:  return {{EXP_W{1'b0}}, w[MANT_W-1:0]};
      default: return w;
    endcase
  endfunction

  logic [DW-1:0] q_all [SLOTS];

  // ---------------- decoding ----------------
  logic              r0_hit, r1_hit, w_hit, ld_hit;
  logic [SLOT_W-1:0] r0_slot, r1_slot, w_slot, ld_slot;
  fview_e            r0_field, r1_field, w_field, ld_field;
  logic [DW-1:0]     ld_data;

  acc_spec_decode #(.GP_N(GP_N), .ACC_N(ACC_N), .SLOT_W(SLOT_W)) u_dec_r0 (
    .spec(rd0_spec), .hit(r0_hit), .slot(r0_slot), .field(r0_field));
  acc_spec_decode #(.GP_N(GP_N), .ACC_N(ACC_N), .SLOT_W(SLOT_W)) u_dec_r1 (
    .spec(rd1_spec), .hit(r1_hit), .slot(r1_slot), .field(r1_field));
  acc_spec_decode #(.GP_N(GP_N), .ACC_N(ACC_N), .SLOT_W(SLOT_W)) u_dec_w (
    .spec(wr_spec), .hit(w_hit), .slot(w_slot), .field(w_field));

  acc_imm_decode #(.GP_N(GP_N), .ACC_N(ACC_N), .DW(DW), .SLOT_W(SLOT_W)) u_dec_ld (
    .valid(ld_valid), .word(ld_word), .hit(ld_hit), .slot(ld_slot),
    .field(ld_field), .data(ld_data));

  // ---------------- write arbitration: load beats port ----------------
  logic              wfire;
  logic [SLOT_W-1:0] wslot;
  fview_e            wfield;
  logic [DW-1:0]     wdata;
  logic              port_fire;

  assign port_fire = wr_en && w_hit && !ld_hit;

  always_comb begin
    wfire  = 1'b0;
    wslot  = '0;
    wfield = F_WHOLE;
    wdata  = '0;
    if (ld_hit) begin
      wfire  = 1'b1;
      wslot  = ld_slot;
      wfield = ld_field;
      wdata  = ld_data;
    end else if (port_fire) begin
      wfire  = 1'b1;
      wslot  = w_slot;
      wfield = w_field;
      wdata  = wr_data;
    end
  end

  // ---------------- storage ----------------
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic             sel, we_hi, we_lo;
    logic [EXP_W-1:0] d_hi;
    logic             int_load;

    assign sel   = wfire && (wslot == SLOT_W'(i));
    assign we_hi = sel && (wfield != F_MANT);
    assign we_lo = sel && (wfield != F_EXP);
    assign d_hi  = (wfield == F_WHOLE) ? wdata[DW-1:MANT_W] : wdata[EXP_W-1:0];
    assign int_load = ld_hit && (ld_slot == SLOT_W'(i)) && (ld_field == F_WHOLE) &&
                      (ld_word[INSN_W-1 -: OPC_W] == OPC_INT24);

    acc_slot_reg #(.DW(DW), .EXP_W(EXP_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .we_hi(we_hi), .we_lo(we_lo),
      .d_hi(d_hi), .d_lo(wdata[MANT_W-1:0]), .q(q_all[i]));

    // R8: an integer load leaves a sign-extended word behind
    a_r8_sign_extended: assert property (@(posedge clk) disable iff (!rst_n)
      int_load |=> (q_all[i][DW-1:IMM_W-1] == {(DW-IMM_W+1){q_all[i][IMM_W-1]}}));
  end

  // ---------------- read ports ----------------
  assign rd0_data = r0_hit ? view_of(q_all[r0_slot], r0_field) : '0;
  assign rd1_data = r1_hit ? view_of(q_all[r1_slot], r1_field) : '0;
  assign rd0_dst  = (rd0_spec[SPEC_W-1:IDX_W] == TY_DEST);
  assign rd1_dst  = (rd1_spec[SPEC_W-1:IDX_W] == TY_DEST);

  // R11: a recognised load suppresses the port write in that cycle
  a_r11_load_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit && wr_en && w_hit && (w_slot != ld_slot)) |=>
      (q_all[$past(w_slot)] == $past(q_all[w_slot])));

endmodule

// File: tb/sim_acc_field_bank.sv
module sim_acc_field_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  rd0_spec = '0, rd1_spec = '0, wr_spec = '0;
  logic [31:0] rd0_data, rd1_data, wr_data = '0, ld_word = '0;
  logic        rd0_dst, rd1_dst, wr_en = 1'b0, ld_valid = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_field_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .rd0_spec(rd0_spec), .rd0_data(rd0_data), .rd0_dst(rd0_dst),
    .rd1_spec(rd1_spec), .rd1_data(rd1_data), .rd1_dst(rd1_dst),
    .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
    .ld_valid(ld_valid), .ld_word(ld_word));

  // ---------------- reference model ----------------
  logic [31:0] m_gen [16];
  logic [31:0] m_acc [4];
  logic [31:0] m_prod;

  function automatic logic [8:0] sp(input int t, input int i);
    return {t[2:0], i[5:0]};
  endfunction

  function automatic logic [31:0] m_read(input logic [8:0] s);
    int t = int'(s[8:6]);
    int i = int'(s[5:0]);
    if (t != 0 && t != 3) return 32'h0;
    if (i < 16) return m_gen[i];
    if (i < 28) begin
      int k = (i - 16) / 3;
      int f = (i - 16) % 3;
      if (f == 0) return m_acc[k];
      if (f == 1) return m_acc[k] >> 24;
      return m_acc[k] & 32'h00FF_FFFF;
    end
    if (i == 28) return m_prod;
    return 32'h0;
  endfunction

  task automatic m_write(input logic [8:0] s, input logic [31:0] d);
    int t = int'(s[8:6]);
    int i = int'(s[5:0]);
    if (t != 0 && t != 3) return;
    if (i < 16) m_gen[i] = d;
    else if (i < 28) begin
      int k = (i - 16) / 3;
      int f = (i - 16) % 3;
      if (f == 0) m_acc[k] = d;
      else if (f == 1) m_acc[k] = {d[7:0], m_acc[k][23:0]};
      else m_acc[k] = {m_acc[k][31:24], d[23:0]};
    end else if (i == 28) m_prod = d;
  endtask

  function automatic bit is_load(input logic [31:0] w);
    return (w[31:26] == 6'd14) || (w[31:26] == 6'd22);
  endfunction

  task automatic m_load(input logic [31:0] w);
    logic [31:0] sx = {{8{w[23]}}, w[23:0]};
    int k;
    if (w[31:26] == 6'd14) begin
      case (w[25:24])
        2'd0: m_prod = sx;
        2'd1: m_acc[0] = sx;
        2'd2: m_acc[1] = sx;
        default: m_acc[3] = sx;
      endcase
    end else begin
      k = w[25] ? 3 : 2;
      if (!w[24]) m_acc[k] = {w[7:0], m_acc[k][23:0]};
      else m_acc[k] = {m_acc[k][31:24], w[23:0]};
    end
  endtask

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag,
                     input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, compare reads against the pre-edge model, apply the edge
  task automatic step(input bit we, input logic [8:0] ws, input logic [31:0] wd,
                      input bit lv, input logic [31:0] lw,
                      input logic [8:0] ra, input logic [8:0] rb, input string tag);
    wr_en = we; wr_spec = ws; wr_data = wd;
    ld_valid = lv; ld_word = lw;
    rd0_spec = ra; rd1_spec = rb;
    #1;
    cmp(rd0_data, m_read(ra), tag, "rd0_data");
    cmp(rd1_data, m_read(rb), tag, "rd1_data");
    cmp({31'b0, rd0_dst}, {31'b0, ra[8:6] == 3'd3}, "R3", "rd0_dst");
    cmp({31'b0, rd1_dst}, {31'b0, rb[8:6] == 3'd3}, "R3", "rd1_dst");
    @(posedge clk);
    if (lv && is_load(lw)) m_load(lw);
    else if (we) m_write(ws, wd);
    @(negedge clk);
  endtask

  task automatic rd(input logic [8:0] a, input logic [8:0] b, input string tag);
    step(0, 9'h0, 32'h0, 0, 32'h0, a, b, tag);
  endtask

  task automatic wr(input logic [8:0] s, input logic [31:0] d, input string tag);
    step(1, s, d, 0, 32'h0, s, s, tag);  // same-cycle read sees old value (R12)
  endtask

  task automatic ld(input logic [31:0] w, input logic [8:0] a, input string tag);
    step(0, 9'h0, 32'h0, 1, w, a, a, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_gen[i] = '0;
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    m_prod = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything reads zero after reset
    for (int i = 0; i < 42; i++) rd(sp(0, i), sp(3, i), "R1");

    // R2: general words at both ends of the range, other types miss
    wr(sp(0, 0), 32'h1234_5678, "R2");
    wr(sp(3, 15), 32'hCAFE_F00D, "R2");
    rd(sp(3, 0), sp(0, 15), "R2");
    wr(sp(2, 5), 32'hDEAD_BEEF, "R2");
    wr(sp(7, 6), 32'h0BAD_0BAD, "R2");
    rd(sp(0, 5), sp(0, 6), "R2");
    rd(sp(1, 0), sp(6, 15), "R2");

    // R4: whole accumulators and p; neighbour 0x0F untouched
    wr(sp(0, 16), 32'hA1A2_A3A4, "R4");
    wr(sp(0, 19), 32'hB1B2_B3B4, "R4");
    wr(sp(3, 22), 32'hC1C2_C3C4, "R4");
    wr(sp(0, 25), 32'hD1D2_D3D4, "R4");
    wr(sp(0, 28), 32'h5555_AAAA, "R4");
    for (int i = 15; i < 30; i++) rd(sp(0, i), sp(3, i), "R4");

    // R5: exponent view with all-ones data
    wr(sp(0, 17), 32'hFFFF_FF5A, "R5");
    wr(sp(0, 26), 32'hFFFF_FFFF, "R5");
    rd(sp(0, 16), sp(0, 17), "R5");
    rd(sp(0, 25), sp(0, 18), "R5");

    // R6: mantissa view with all-ones data
    wr(sp(0, 21), 32'hFFFF_FFFF, "R6");
    wr(sp(3, 24), 32'h0012_3456, "R6");
    rd(sp(0, 19), sp(0, 21), "R6");
    rd(sp(0, 22), sp(0, 23), "R6");

    // R7: holes and queue ports ignore writes and read zero
    wr(sp(0, 29), 32'hFFFF_FFFF, "R7");
    wr(sp(0, 33), 32'h1111_1111, "R7");
    wr(sp(0, 34), 32'h2222_2222, "R7");
    wr(sp(0, 63), 32'h3333_3333, "R7");
    for (int i = 0; i < 64; i++) rd(sp(0, i), sp(3, i), "R7");

    // R8: integer loads, negative and positive
    ld({6'd14, 2'd0, 24'h80_0001}, sp(0, 28), "R8");
    ld({6'd14, 2'd1, 24'hFF_FFFE}, sp(0, 16), "R8");
    ld({6'd14, 2'd2, 24'h7F_FFFF}, sp(0, 19), "R8");
    ld({6'd14, 2'd3, 24'h90_0000}, sp(0, 25), "R8");
    rd(sp(0, 28), sp(0, 16), "R8");
    rd(sp(0, 19), sp(0, 25), "R8");
    rd(sp(0, 22), sp(0, 22), "R8");

    // R9: float-field loads
    ld({6'd22, 2'd0, 24'hABCD_EF}, sp(0, 22), "R9");
    ld({6'd22, 2'd1, 24'h65_4321}, sp(0, 22), "R9");
    ld({6'd22, 2'd2, 24'hFFFF_81}, sp(0, 25), "R9");
    ld({6'd22, 2'd3, 24'h00_0007}, sp(0, 25), "R9");
    rd(sp(0, 22), sp(0, 25), "R9");
    rd(sp(0, 23), sp(0, 27), "R9");

    // R10: unknown opcodes do nothing
    ld({6'd15, 2'd1, 24'h12_3456}, sp(0, 16), "R10");
    ld({6'd0, 2'd0, 24'hFF_FFFF}, sp(0, 28), "R10");
    rd(sp(0, 16), sp(0, 28), "R10");

    // R11: load wins over a port write in the same cycle
    step(1, sp(0, 3), 32'hEEEE_EEEE, 1, {6'd14, 2'd1, 24'h00_0042}, sp(0, 3), sp(0, 16), "R11");
    step(1, sp(0, 19), 32'h7777_7777, 1, {6'd14, 2'd2, 24'h80_0000}, sp(0, 19), sp(0, 19), "R11");
    rd(sp(0, 3), sp(0, 16), "R11");
    rd(sp(0, 19), sp(0, 19), "R11");
    // bad opcode does not block the port write
    step(1, sp(0, 4), 32'h4444_4444, 1, {6'd1, 26'h0}, sp(0, 4), sp(0, 4), "R11");
    rd(sp(0, 4), sp(0, 4), "R11");

    // R12: back-to-back writes to one location
    wr(sp(0, 7), 32'h0000_0001, "R12");
    wr(sp(0, 7), 32'h0000_0002, "R12");
    rd(sp(0, 7), sp(0, 7), "R12");

    // mixed traffic (R2, R4, R5, R6, R7, R8, R9, R11)
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 8;
      int t = (r < 3) ? 0 : ((r < 6) ? 3 : r);
      int o = $urandom % 3;
      logic [5:0] opc = (o == 0) ? 6'd14 : ((o == 1) ? 6'd22 : 6'($urandom));
      step(($urandom % 2) == 1, sp(t, $urandom % 42), $urandom,
           ($urandom % 4) == 0, {opc, 26'($urandom)},
           sp(($urandom % 3 == 0) ? 3 : 0, $urandom % 42), sp(0, $urandom % 42),
           "R4/mix");
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule